// File: doc/BRIEF.md
# DMA Burst-Wrap Address Generator

This block supplies the source and destination addresses of one DMA channel. A start pulse captures the two start addresses, a transfer-size code, a burst exponent N and one wrap-enable bit per side. After that, each acknowledged transfer moves both addresses forward by the transfer size. A shared counter tracks the position of the current transfer inside a burst of 2^N transfers.

A side with wrapping enabled returns to its job start address at the end of every burst, so each burst on that side covers the same window of 2^N transfers. This suits repeated reads or writes of a small bank of consecutive peripheral registers. A side with wrapping disabled keeps advancing linearly across burst boundaries. The block does not handle triggers, data movement or bus protocol. It tracks position and the next address, and nothing else.

Top module: `dwa_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, both address outputs and the burst position are zero.
- R2: A start pulse loads both start addresses and clears the burst position. The values appear on the outputs one cycle later. A start in the same cycle as an acknowledge takes priority, and that acknowledge causes no advance.
- R3: Each acknowledge advances a non-wrapping address by the transfer size: code 0 gives 1 byte, code 1 gives 2, code 2 gives 4, and code 3 also gives 4.
- R4: When there is no acknowledge and no start, both addresses and the burst position hold their values.
- R5: With wrapping off, a side keeps incrementing across burst boundaries. After k acknowledges its address is start + k*size.
- R6: With wrapping on, a side goes back to its job start address after every 2^N acknowledges. After k acknowledges its address is start + (k mod 2^N)*size.
- R7: The source and destination wrap controls act independently. Each side follows R5 or R6 according to its own bit.
- R8: Exponent 0 gives a window of one transfer, so a wrapping side stays at its start address. With the default limit of 10, an exponent above 10 behaves as 10, giving a window of 1024.
- R9: The burst position counts 0 to 2^N-1 on acknowledges and then returns to 0. It always equals k mod 2^N.
- R10: All configuration inputs are sampled only on start. Changing them during a job has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job start pulse; captures configuration |
| src_start_i | input | ADDR_W (32) | Source start address |
| dst_start_i | input | ADDR_W (32) | Destination start address |
| xfer_size_i | input | 2 | Transfer size code (0:1 B, 1:2 B, 2/3:4 B) |
| burst_exp_i | input | EXP_W (4) | Burst exponent N; window is 2^N transfers |
| src_wrap_i | input | 1 | Source wrap enable |
| dst_wrap_i | input | 1 | Destination wrap enable |
| ack_i | input | 1 | Transfer acknowledged; advance both sides |
| src_addr_o | output | ADDR_W (32) | Registered next source address |
| dst_addr_o | output | ADDR_W (32) | Registered next destination address |
| burst_pos_o | output | MAX_EXP (10) | Position of the next transfer inside the burst |

## Verification
The hardest state to reach from the ports is the end of the largest window. There, the 1024th acknowledge must wrap one side back to its start while the other side keeps going past the window. The same state must also be reached through an out-of-range exponent that clamps to the limit. The stimulus gets there by holding acknowledge for more than 1024 consecutive cycles, once with exponent 10 and once with exponent 15. It then compares both addresses and the position against the modulo formula. Changing configuration inputs mid-job and the start/acknowledge collision are driven as separate directed cases.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

   typedef enum logic [1:0] {
      XS_BYTE  = 2'd0,
      XS_HALF  = 2'd1,
      XS_WORD  = 2'd2,
      XS_WORD2 = 2'd3
   } xfer_size_e;

   // Byte increment for a transfer-size code.
   function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
      logic [2:0] b;
      case (xfer_size_e'(code))
         XS_BYTE: b = 3'd1;
         XS_HALF: b = 3'd2;
         default: b = 3'd4;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/dwa_burst_counter.sv
module dwa_burst_counter #(
   parameter int MAX_EXP = 10,
   parameter int EXP_W   = 4,
   localparam int CNT_W  = MAX_EXP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic [CNT_W-1:0] pos_o,
   output logic             last_o
);

   logic [CNT_W:0]   window;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] pos_q;

   // 2^exp, then minus one; exp == CNT_W gives all ones in the low bits.
   assign window   = (CNT_W+1)'(1) << exp_i;
   assign last_idx = CNT_W'(window - (CNT_W+1)'(1));
   assign last_o   = (pos_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (load_i) begin
         pos_q <= '0;
      end else if (adv_i) begin
         if (last_o) pos_q <= '0;
         else        pos_q <= pos_q + CNT_W'(1);
      end
   end

   assign pos_o = pos_q;

   p_pos_in_window_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= last_idx);

   p_restart_at_end_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && last_o) |=> (pos_q == '0));

   p_load_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (pos_q == '0));

   p_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> $stable(pos_q));

endmodule

// File: rtl/dwa_addr_side.sv
module dwa_addr_side #(
   parameter int ADDR_W       = 32,
   parameter bit WRAP_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              wrap_i,
   input  logic [2:0]        inc_i,
   input  logic              burst_last_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wrap_q;

   generate
      if (WRAP_CAPABLE) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      wrap_q <= 1'b0;
            else if (load_i) wrap_q <= wrap_i;
         end
      end else begin : g_linear
         assign wrap_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         addr_q <= base_i;
      end else if (adv_i) begin
         if (wrap_q && burst_last_i) addr_q <= base_q;
         else                        addr_q <= addr_q + ADDR_W'(inc_i);
      end
   end

   assign addr_o = addr_q;

   p_load_base_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_q == $past(base_i)));

   p_linear_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && !wrap_q) |=> (addr_q == $past(addr_q) + ADDR_W'($past(inc_i))));

   p_wrap_return_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && wrap_q && burst_last_i) |=> (addr_q == base_q));

   p_addr_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> $stable(addr_q));

endmodule

// File: rtl/dwa_addr_gen.sv
module dwa_addr_gen #(
   parameter int ADDR_W       = 32,
   parameter int MAX_EXP      = 10,
   parameter int EXP_W        = 4,
   parameter bit WRAP_CAPABLE = 1'b1,
   localparam int CNT_W       = MAX_EXP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] src_start_i,
   input  logic [ADDR_W-1:0] dst_start_i,
   input  logic [1:0]        xfer_size_i,
   input  logic [EXP_W-1:0]  burst_exp_i,
   input  logic              src_wrap_i,
   input  logic              dst_wrap_i,
   input  logic              ack_i,
   output logic [ADDR_W-1:0] src_addr_o,
   output logic [ADDR_W-1:0] dst_addr_o,
   output logic [CNT_W-1:0]  burst_pos_o
);

   localparam int NSIDE = 2;

   generate
      if (MAX_EXP < 1 || MAX_EXP > 20) begin : g_bad_exp
         $error("dwa_addr_gen: MAX_EXP out of range");
      end
      if ((1 << EXP_W) <= MAX_EXP) begin : g_bad_expw
         $error("dwa_addr_gen: EXP_W too narrow for MAX_EXP");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("dwa_addr_gen: ADDR_W too small");
      end
   endgenerate

   logic [1:0]       size_q;
   logic [EXP_W-1:0] exp_q;
   logic [EXP_W-1:0] exp_ld;
   logic [2:0]       inc;
   logic             adv;
   logic             burst_last;

   assign exp_ld = (burst_exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : burst_exp_i;
   assign adv    = ack_i && !start_i;
   assign inc    = dwa_pkg::size_to_bytes(size_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         exp_q  <= '0;
      end else if (start_i) begin
         size_q <= xfer_size_i;
         exp_q  <= exp_ld;
      end
   end

   dwa_burst_counter #(
      .MAX_EXP (MAX_EXP),
      .EXP_W   (EXP_W)
   ) i_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .adv_i  (adv),
      .exp_i  (exp_q),
      .pos_o  (burst_pos_o),
      .last_o (burst_last)
   );

   logic [ADDR_W-1:0] side_base [NSIDE];
   logic              side_wrap [NSIDE];
   logic [ADDR_W-1:0] side_addr [NSIDE];

   assign side_base[0] = src_start_i;
   assign side_base[1] = dst_start_i;
   assign side_wrap[0] = src_wrap_i;
   assign side_wrap[1] = dst_wrap_i;

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         dwa_addr_side #(
            .ADDR_W       (ADDR_W),
            .WRAP_CAPABLE (WRAP_CAPABLE)
         ) i_side (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (start_i),
            .adv_i        (adv),
            .base_i       (side_base[s]),
            .wrap_i       (side_wrap[s]),
            .inc_i        (inc),
            .burst_last_i (burst_last),
            .addr_o       (side_addr[s])
         );
      end
   endgenerate

   assign src_addr_o = side_addr[0];
   assign dst_addr_o = side_addr[1];

   p_exp_clamped_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (exp_q <= EXP_W'(MAX_EXP)));

   p_cfg_held_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(exp_q) && $stable(size_q)));

endmodule

// File: tb/test_dwa_addr_gen.sv
module test_dwa_addr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 10;

   typedef struct packed {
      logic [1:0]  w;
      logic [3:0]  e;
      logic        sw;
      logic        dw;
      logic [15:0] n;
      logic [31:0] sb;
      logic [31:0] db;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 4'd2,  1'b1, 1'b0, 16'd9,    32'h0000_1000, 32'h0000_2000},
      '{2'd1, 4'd3,  1'b0, 1'b1, 16'd16,   32'h0000_3000, 32'h0000_4010},
      '{2'd2, 4'd1,  1'b1, 1'b1, 16'd5,    32'h0001_0000, 32'h0002_0000},
      '{2'd3, 4'd4,  1'b0, 1'b0, 16'd20,   32'h0000_0100, 32'h0000_0200},
      '{2'd2, 4'd10, 1'b1, 1'b0, 16'd1030, 32'h4000_0000, 32'h5000_0000},
      '{2'd1, 4'd0,  1'b1, 1'b1, 16'd7,    32'h0000_0040, 32'h0000_0080}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_start = '0;
   logic [AW-1:0] dst_start = '0;
   logic [1:0]    xsize = '0;
   logic [3:0]    bexp = '0;
   logic          swrap = 1'b0;
   logic          dwrap = 1'b0;
   logic          ack = 1'b0;
   logic [AW-1:0] src_addr;
   logic [AW-1:0] dst_addr;
   logic [CW-1:0] pos;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dwa_addr_gen i_dwa_addr_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .src_start_i (src_start),
      .dst_start_i (dst_start),
      .xfer_size_i (xsize),
      .burst_exp_i (bexp),
      .src_wrap_i  (swrap),
      .dst_wrap_i  (dwrap),
      .ack_i       (ack),
      .src_addr_o  (src_addr),
      .dst_addr_o  (dst_addr),
      .burst_pos_o (pos)
   );

   function automatic int bytes_of(input logic [1:0] w);
      return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
   endfunction

   function automatic int win_of(input logic [3:0] e);
      return 1 << ((e > 4'd10) ? 10 : int'(e));
   endfunction

   function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] base, input logic [1:0] w,
                                                input logic [3:0] e, input logic wr, input int k);
      int p;
      p = wr ? (k % win_of(e)) : k;
      return base + AW'(p * bytes_of(w));
   endfunction

   task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic do_start(input logic [1:0] w, input logic [3:0] e, input logic sw, input logic dw,
                           input logic [AW-1:0] sb, input logic [AW-1:0] db, input logic with_ack);
      @(negedge clk);
      xsize = w; bexp = e; swrap = sw; dwrap = dw;
      src_start = sb; dst_start = db;
      start = 1'b1; ack = with_ack;
      @(negedge clk);
      start = 1'b0; ack = 1'b0;
   endtask

   task automatic do_acks(input int n);
      if (n > 0) begin
         ack = 1'b1;
         repeat (n) @(negedge clk);
         ack = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 src", src_addr, '0);
      check("R1 dst", dst_addr, '0);
      check("R1 pos", AW'(pos), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 src after release", src_addr, '0);

      // Table-driven jobs: R3 R5 R6 R7 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VEC[i];
         do_start(v.w, v.e, v.sw, v.dw, v.sb, v.db, 1'b0);
         check("R2 src load", src_addr, v.sb);
         check("R2 dst load", dst_addr, v.db);
         check("R2 pos clear", AW'(pos), '0);
         do_acks(int'(v.n));
         check(v.sw ? "R6 R7 src wrap" : "R3 R5 src linear", src_addr,
               model_addr(v.sb, v.w, v.e, v.sw, int'(v.n)));
         check(v.dw ? "R6 R7 dst wrap" : "R3 R5 dst linear", dst_addr,
               model_addr(v.db, v.w, v.e, v.dw, int'(v.n)));
         check("R9 pos", AW'(pos), AW'(int'(v.n) % win_of(v.e)));
      end

      // R4: no acknowledge, outputs hold
      do_start(2'd2, 4'd3, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_9000, 1'b0);
      do_acks(3);
      repeat (6) @(negedge clk);
      check("R4 src hold", src_addr, 32'h0000_800C);
      check("R4 dst hold", dst_addr, 32'h0000_900C);
      check("R4 pos hold", AW'(pos), 32'd3);

      // R2: start and acknowledge together, start wins
      do_start(2'd2, 4'd2, 1'b0, 1'b0, 32'h0000_A000, 32'h0000_B000, 1'b1);
      check("R2 start+ack src", src_addr, 32'h0000_A000);
      check("R2 start+ack pos", AW'(pos), '0);

      // R10: configuration changes mid-job are ignored
      do_start(2'd2, 4'd2, 1'b1, 1'b0, 32'h0000_C000, 32'h0000_D000, 1'b0);
      @(negedge clk);
      xsize = 2'd0; bexp = 4'd0; swrap = 1'b0; dwrap = 1'b1;
      src_start = 32'h1111_0000; dst_start = 32'h2222_0000;
      do_acks(5);
      check("R10 src", src_addr, 32'h0000_C004);
      check("R10 dst", dst_addr, 32'h0000_D014);
      check("R10 pos", AW'(pos), 32'd1);

      // R8: exponent above limit behaves as 10
      do_start(2'd1, 4'd15, 1'b1, 1'b0, 32'h0000_0010, 32'h0000_0020, 1'b0);
      do_acks(1025);
      check("R8 clamp src", src_addr, 32'h0000_0012);
      check("R8 clamp dst", dst_addr, 32'h0000_0020 + 32'd2050);
      check("R8 clamp pos", AW'(pos), 32'd1);

      // R8: exponent 0 keeps a wrapping side on its start address
      do_start(2'd2, 4'd0, 1'b1, 1'b0, 32'h0000_0300, 32'h0000_0400, 1'b0);
      do_acks(3);
      check("R8 exp0 src", src_addr, 32'h0000_0300);
      check("R8 exp0 dst", dst_addr, 32'h0000_040C);
      check("R8 exp0 pos", AW'(pos), '0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule